// File: doc/BRIEF.md
# Page-Program Row-Erase Flash Controller

This block combines a sequencer with a behavioural storage array for a small flash-like memory. The array is divided into rows. Each row holds eight pages, and each page holds eight bytes. A host issues one request at a time, each with an operation code, a byte address and a page-wide data word. The block answers a byte read, a page program or a row erase. It holds `busy` high while it works, then raises `done` for one cycle together with a status code.

Cleared cells read as 0, and a program can only turn bits from 0 to 1. Each cell holds a small strength count. One program pulse raises the count of every cell that is being programmed. A normal read reports 1 when the count is non-zero. A margin check needs the count to reach `MARGIN`. A program repeats a pulse followed by a margin check, and it stops at the first check that passes for every targeted bit of the page. The block keeps a count of how many programs each row has taken since its last erase. It refuses a program once that count reaches the limit.

Top module: `flc_top`

## Requirements
- R1: Reset erases the whole array, so every byte then reads 0x00. Reset also leaves `busy`, `done` and `status` at 0.
- R2: `addr[2:0]` picks the byte within a page, `addr[5:3]` picks the page, and the upper bits pick the row. A read (`op` 0, and `op` 3 as an alias) keeps `busy` high for 1 cycle and returns that byte on `rdata` with `done`.
- R3: A program (`op` 1) sets to 1 every bit of the addressed page whose `wdata` bit is 1. Byte k of the page takes `wdata[8k+7:8k]`. A program never clears a bit and never touches any other page.
- R4: A program keeps `busy` high for 2 cycles plus one cycle per pulse it issues. Pulses stop as soon as every targeted bit passes the margin check. A fresh page therefore needs `MARGIN` pulses, and a page that is already strong needs none.
- R5: A row erase (`op` 2) clears all 64 bytes of the addressed row to 0 and leaves the other rows unchanged. It keeps `busy` high for 1 cycle.
- R6: Once a row has taken `PROG_LIMIT` programs since its last erase, a further program to that row ends after 1 busy cycle with status 1 (limit). That program leaves the array unchanged.
- R7: A row erase resets that row's program count, so programs to the row are accepted again.
- R8: If the margin check still fails after `MAX_PULSES` pulses, the program ends with status 2 (verify failure). The pulsed bits still read as 1.
- R9: A request that arrives while `busy` is high is ignored.
- R10: `done` is high for exactly one cycle and never together with `busy`. Status 0 means success.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, sampled when idle |
| op | input | 2 | 0 read, 1 program page, 2 erase row, 3 read |
| addr | input | 7 | Byte address {row, page, byte} |
| wdata | input | 64 | Page data for a program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 row limit, 2 verify failure |
| rdata | output | 8 | Byte returned by the last read |

## Verification
The program loop is tried against four kinds of page data:
- A page programmed from fresh. This confirms that exactly `MARGIN` pulses are issued.
- Data that overlaps bits which are already strong. Only the new bits should cost pulses.
- Data that repeats bits which are already strong. This should finish with no pulse.
- All-zero data. This should finish with no pulse but still count toward the row limit.

The busy-cycle count separates these four cases. Reads of neighbouring bytes, pages and rows show that programs and erases stay within their page or row. A second instance with a pulse budget below the margin makes the verify-failure path reachable.

// File: rtl/flc_pkg.sv
package flc_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_READ2 = 2'd3
  } flc_op_e;

  typedef enum logic [1:0] {
    STS_OK    = 2'd0,
    STS_LIMIT = 2'd1,
    STS_VFAIL = 2'd2,
    STS_RSVD  = 2'd3
  } flc_status_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_CHECK  = 2'd1,
    S_VERIFY = 2'd2
  } flc_state_e;
endpackage

// File: rtl/flc_rst_sync.sv
module flc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/flc_cells.sv
module flc_cells #(
  parameter int ROWS   = 2,
  parameter int PAGES  = 8,
  parameter int BYTES  = 8,
  parameter int STR_W  = 2,
  parameter int MARGIN = 2,
  localparam int PAGE_BITS = BYTES * 8,
  localparam int BW = $clog2(BYTES),
  localparam int PW = $clog2(PAGES),
  localparam int RW = $clog2(ROWS),
  localparam int AW = RW + PW + BW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic                 erase_en,
  input  logic                 pulse_en,
  input  logic [PAGE_BITS-1:0] mask,
  output logic [7:0]           rdata,
  output logic                 margin_ok
);
  localparam int ROW_BITS = PAGES * PAGE_BITS;
  localparam int CELLS    = ROWS * ROW_BITS;
  localparam int CW       = $clog2(CELLS);
  localparam int PBW      = $clog2(PAGE_BITS);
  localparam int RBW      = $clog2(ROW_BITS);
  localparam logic [STR_W-1:0] SMAX = '1;

  logic [STR_W-1:0] str_q [CELLS];
  logic [STR_W-1:0] str_d [CELLS];
  logic [CW-1:0]    row_base, page_base, byte_base;

  assign row_base  = {addr[AW-1 -: RW], {RBW{1'b0}}};
  assign page_base = {addr[AW-1:BW], {PBW{1'b0}}};
  assign byte_base = {addr, 3'b000};

  always_comb begin
    str_d = str_q;
    if (erase_en) begin
      for (int j = 0; j < ROW_BITS; j++) str_d[row_base + CW'(j)] = '0;
    end else if (pulse_en) begin
      for (int j = 0; j < PAGE_BITS; j++) begin
        if (mask[j] && (str_q[page_base + CW'(j)] != SMAX))
          str_d[page_base + CW'(j)] = str_q[page_base + CW'(j)] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) str_q[i] <= '0;
    end else if (erase_en || pulse_en) begin
      str_q <= str_d;
    end
  end

  always_comb begin
    for (int b = 0; b < 8; b++) rdata[b] = |str_q[byte_base + CW'(b)];
  end

  always_comb begin
    margin_ok = 1'b1;
    for (int j = 0; j < PAGE_BITS; j++) begin
      if (mask[j] && (str_q[page_base + CW'(j)] < STR_W'(MARGIN))) margin_ok = 1'b0;
    end
  end
endmodule

// File: rtl/flc_rowcnt.sv
module flc_rowcnt #(
  parameter int ROWS  = 2,
  parameter int LIMIT = 8,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] row,
  input  logic          inc_en,
  input  logic          clr_en,
  output logic          full
);
  localparam int CNTW = $clog2(LIMIT + 1);

  logic [ROWS-1:0] full_vec;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [CNTW-1:0] cnt_q;
    logic            hit;
    assign hit = (row == RW'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clr_en && hit)   cnt_q <= '0;
      else if (inc_en && hit)   cnt_q <= cnt_q + 1'b1;
    end

    assign full_vec[r] = (cnt_q >= CNTW'(LIMIT));
  end

  assign full = full_vec[row];
endmodule

// File: rtl/flc_top.sv
module flc_top
  import flc_pkg::*;
#(
  parameter int ROWS       = 2,
  parameter int PAGES      = 8,
  parameter int BYTES      = 8,
  parameter int STR_W      = 2,
  parameter int MARGIN     = 2,
  parameter int MAX_PULSES = 16,
  parameter int PROG_LIMIT = 8,
  localparam int PAGE_BITS = BYTES * 8,
  localparam int RW = $clog2(ROWS),
  localparam int AW = RW + $clog2(PAGES) + $clog2(BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic [1:0]           op,
  input  logic [AW-1:0]        addr,
  input  logic [PAGE_BITS-1:0] wdata,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           status,
  output logic [7:0]           rdata
);
  localparam int PCW = $clog2(MAX_PULSES + 1);

  logic                 rst_s_n;
  flc_state_e           st_q, st_d;
  flc_op_e              op_q;
  logic [AW-1:0]        addr_q;
  logic [PAGE_BITS-1:0] data_q;
  logic [PCW-1:0]       pcnt_q, pcnt_d;
  flc_status_e          status_q, status_d;
  logic                 done_q, done_d;
  logic [7:0]           rdata_q, cell_rdata;
  logic                 cap, fin, rd_load;
  logic                 erase_en, pulse_en, inc_en, row_full, margin_ok;

  flc_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_s_n));

  flc_cells #(
    .ROWS(ROWS), .PAGES(PAGES), .BYTES(BYTES), .STR_W(STR_W), .MARGIN(MARGIN)
  ) u_cells (
    .clk(clk), .rst_n(rst_s_n), .addr(addr_q), .erase_en(erase_en),
    .pulse_en(pulse_en), .mask(data_q), .rdata(cell_rdata), .margin_ok(margin_ok)
  );

  flc_rowcnt #(.ROWS(ROWS), .LIMIT(PROG_LIMIT)) u_rowcnt (
    .clk(clk), .rst_n(rst_s_n), .row(addr_q[AW-1 -: RW]),
    .inc_en(inc_en), .clr_en(erase_en), .full(row_full)
  );

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    pcnt_d   = pcnt_q;
    status_d = status_q;
    cap      = 1'b0;
    fin      = 1'b0;
    rd_load  = 1'b0;
    erase_en = 1'b0;
    pulse_en = 1'b0;
    inc_en   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (req) begin
          cap  = 1'b1;
          st_d = S_CHECK;
        end
      end
      S_CHECK: begin
        unique case (op_q)
          OP_PROG: begin
            if (row_full) begin
              fin      = 1'b1;
              status_d = STS_LIMIT;
            end else begin
              inc_en = 1'b1;
              pcnt_d = '0;
              st_d   = S_VERIFY;
            end
          end
          OP_ERASE: begin
            erase_en = 1'b1;
            fin      = 1'b1;
            status_d = STS_OK;
          end
          default: begin
            rd_load  = 1'b1;
            fin      = 1'b1;
            status_d = STS_OK;
          end
        endcase
      end
      S_VERIFY: begin
        if (margin_ok) begin
          fin      = 1'b1;
          status_d = STS_OK;
        end else if (pcnt_q == PCW'(MAX_PULSES)) begin
          fin      = 1'b1;
          status_d = STS_VFAIL;
        end else begin
          pulse_en = 1'b1;
          pcnt_d   = pcnt_q + 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (fin) st_d = S_IDLE;
    done_d = fin;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q     <= S_IDLE;
      op_q     <= OP_READ;
      addr_q   <= '0;
      data_q   <= '0;
      pcnt_q   <= '0;
      status_q <= STS_OK;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      st_q   <= st_d;
      pcnt_q <= pcnt_d;
      done_q <= done_d;
      if (cap) begin
        op_q   <= flc_op_e'(op);
        addr_q <= addr;
        data_q <= wdata;
      end
      if (fin)     status_q <= status_d;
      if (rd_load) rdata_q  <= cell_rdata;
    end
  end

  assign busy   = (st_q != S_IDLE);
  assign done   = done_q;
  assign status = status_q;
  assign rdata  = rdata_q;
endmodule

// File: rtl/flc_chk.sv
module flc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [1:0] status,
  input logic [1:0] op_q,
  input logic       pulse_en,
  input logic       erase_en
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
  // R9
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q));
  // R6
  limit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd1) |-> op_q == 2'd1);
  // R8
  vfail_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd2) |-> op_q == 2'd1);
  // R4
  pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_en |-> (busy && op_q == 2'd1));
  // R5
  erase_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |-> (busy && op_q == 2'd2));
endmodule

bind flc_top flc_chk u_flc_chk (
  .clk(clk), .rst_n(rst_s_n), .busy(busy), .done(done), .status(status),
  .op_q(op_q), .pulse_en(pulse_en), .erase_en(erase_en)
);

// File: tb/test_flc_top.sv
`timescale 1ns/1ps
module test_flc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req2;
  logic [1:0]  op, op2;
  logic [6:0]  addr, addr2;
  logic [63:0] wdata, wdata2;
  logic        busy, done, busy2, done2;
  logic [1:0]  status, status2;
  logic [7:0]  rdata, rdata2;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  flc_top i_flc_top (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .status(status), .rdata(rdata)
  );

  flc_top #(.MAX_PULSES(1)) i_flc_top_weak (
    .clk(clk), .rst_n(rst_n), .req(req2), .op(op2), .addr(addr2), .wdata(wdata2),
    .busy(busy2), .done(done2), .status(status2), .rdata(rdata2)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  addr;
    logic [63:0] data;
    logic [1:0]  st;
    logic [7:0]  rd;
    int          cyc;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 7'h00, 64'h0,                  2'd0, 8'h00, 1},
    '{2'd1, 7'h08, 64'hA55A,               2'd0, 8'h00, 4},
    '{2'd0, 7'h08, 64'h0,                  2'd0, 8'h5A, 1},
    '{2'd0, 7'h09, 64'h0,                  2'd0, 8'hA5, 1},
    '{2'd0, 7'h0A, 64'h0,                  2'd0, 8'h00, 1},
    '{2'd1, 7'h08, 64'h0F,                 2'd0, 8'h00, 4},
    '{2'd0, 7'h08, 64'h0,                  2'd0, 8'h5F, 1},
    '{2'd1, 7'h08, 64'h5A,                 2'd0, 8'h00, 2},
    '{2'd1, 7'h10, 64'h0,                  2'd0, 8'h00, 2},
    '{2'd1, 7'h7F, 64'hFF00000000000000,   2'd0, 8'h00, 4},
    '{2'd0, 7'h7F, 64'h0,                  2'd0, 8'hFF, 1},
    '{2'd0, 7'h38, 64'h0,                  2'd0, 8'h00, 1},
    '{2'd2, 7'h15, 64'h0,                  2'd0, 8'h00, 1},
    '{2'd0, 7'h08, 64'h0,                  2'd0, 8'h00, 1},
    '{2'd0, 7'h09, 64'h0,                  2'd0, 8'h00, 1},
    '{2'd0, 7'h7F, 64'h0,                  2'd0, 8'hFF, 1},
    '{2'd3, 7'h7F, 64'h0,                  2'd0, 8'hFF, 1}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] o, input logic [6:0] a, input logic [63:0] d,
                       output logic [1:0] s, output logic [7:0] r, output int c);
    @(negedge clk);
    req = 1'b1; op = o; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    c = 0;
    while (!done && c < 100) begin
      c++;
      @(negedge clk);
    end
    chk(c < 100, "R10 done timeout", 64'(c), 64'd100);
    s = status;
    r = rdata;
    chk(!busy, "R10 busy with done", 64'(busy), 64'd0);
    @(negedge clk);
    chk(!done, "R10 done width", 64'(done), 64'd0);
  endtask

  task automatic do_op2(input logic [1:0] o, input logic [6:0] a, input logic [63:0] d,
                        output logic [1:0] s, output logic [7:0] r, output int c);
    @(negedge clk);
    req2 = 1'b1; op2 = o; addr2 = a; wdata2 = d;
    @(negedge clk);
    req2 = 1'b0;
    c = 0;
    while (!done2 && c < 100) begin
      c++;
      @(negedge clk);
    end
    s = status2;
    r = rdata2;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] s;
    logic [7:0] r;
    int         c;
    req = 0; op = 0; addr = 0; wdata = 0;
    req2 = 0; op2 = 0; addr2 = 0; wdata2 = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(!busy, "R1 busy", 64'(busy), 0);
    chk(!done, "R1 done", 64'(done), 0);
    chk(status == 2'd0, "R1 status", 64'(status), 0);

    // Vector table: R2 reads, R3 data, R4 pulse counts, R5 erase
    for (int i = 0; i < NV; i++) begin
      string t;
      t = (VEC[i].op == 2'd1) ? "R4" : (VEC[i].op == 2'd2) ? "R5" : "R2";
      do_op(VEC[i].op, VEC[i].addr, VEC[i].data, s, r, c);
      chk(s == VEC[i].st, {t, " status"}, 64'(s), 64'(VEC[i].st));
      chk(c == VEC[i].cyc, {t, " busy cycles"}, 64'(c), 64'(VEC[i].cyc));
      if (VEC[i].op == 2'd0 || VEC[i].op == 2'd3)
        chk(r == VEC[i].rd, "R3 read data", 64'(r), 64'(VEC[i].rd));
    end

    // R6 row program limit on row 0 (count cleared by the erase above)
    for (int p = 0; p < 8; p++) begin
      do_op(2'd1, 7'(p << 3), 64'h1, s, r, c);
      chk(s == 2'd0, "R6 program within limit", 64'(s), 0);
    end
    do_op(2'd1, 7'h00, 64'h80, s, r, c);
    chk(s == 2'd1, "R6 ninth program status", 64'(s), 1);
    chk(c == 1, "R6 ninth program cycles", 64'(c), 1);
    do_op(2'd0, 7'h00, 64'h0, s, r, c);
    chk(r == 8'h01, "R6 array unchanged", 64'(r), 64'h01);

    // R7 erase clears the row count
    do_op(2'd2, 7'h00, 64'h0, s, r, c);
    do_op(2'd1, 7'h00, 64'h80, s, r, c);
    chk(s == 2'd0, "R7 program after erase", 64'(s), 0);
    do_op(2'd0, 7'h00, 64'h0, s, r, c);
    chk(r == 8'h80, "R7 data after erase", 64'(r), 64'h80);

    // R9 requests while busy are ignored
    @(negedge clk);
    req = 1'b1; op = 2'd1; addr = 7'h40; wdata = 64'hFF;
    @(negedge clk);
    op = 2'd2; addr = 7'h40;
    @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    c = 2;
    while (!done && c < 100) begin
      c++;
      @(negedge clk);
    end
    chk(status == 2'd0, "R9 program status", 64'(status), 0);
    chk(c == 4, "R9 program cycles", 64'(c), 4);
    @(negedge clk);
    chk(!busy, "R9 no second operation", 64'(busy), 0);
    do_op(2'd0, 7'h40, 64'h0, s, r, c);
    chk(r == 8'hFF, "R9 programmed byte kept", 64'(r), 64'hFF);
    do_op(2'd0, 7'h7F, 64'h0, s, r, c);
    chk(r == 8'hFF, "R9 row not erased", 64'(r), 64'hFF);

    // R8 verify failure on the weak instance
    do_op2(2'd1, 7'h00, 64'h1, s, r, c);
    chk(s == 2'd2, "R8 verify failure status", 64'(s), 2);
    chk(c == 3, "R8 verify failure cycles", 64'(c), 3);
    do_op2(2'd0, 7'h00, 64'h0, s, r, c);
    chk(r == 8'h01, "R8 pulsed bit reads one", 64'(r), 64'h01);

    // R1 reset erases the array
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_op(2'd0, 7'h7F, 64'h0, s, r, c);
    chk(r == 8'h00, "R1 erased after reset", 64'(r), 0);
    do_op(2'd0, 7'h00, 64'h0, s, r, c);
    chk(r == 8'h00, "R1 erased after reset", 64'(r), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule